// File: doc/BRIEF.md
# Serial Line Receiver with Error-Tagged Receive Queue

This block takes an asynchronous serial input line and turns it into a queue of received characters. A programmable clock divisor produces an oversampling tick at sixteen times the bit rate. Each bit is sampled at the centre of its sixteen ticks. The character format can be set to 5 to 8 data bits, with even, odd or no parity and one stop bit. Every character enters a 64-entry queue with its own parity, framing and break flags. The host reads the oldest entry and its flags directly from the output port, then pops it.

The block also reports three conditions. A sticky overflow flag shows that a character arrived while the queue was full. A line-idle flag shows that queued data has been waiting with no new start bit for four character times. A request output asserts when the fill level reaches a selectable threshold, and can drive an interrupt or a DMA request.

Top module: `rx_line_fifo`

## Requirements
- R1: `wordLen` sets the number of data bits: 0 gives 5, 1 gives 6, 2 gives 7, 3 gives 8. Data bits arrive least significant first. The stored byte is zero-extended above the last data bit.
- R2: When `parityEn` is 1, a parity bit follows the data bits. `parityOdd`=0 selects even parity and 1 selects odd parity. An entry's parity-error flag is 1 when the data and parity bits together hold the wrong count of ones. When `parityEn` is 0 there is no parity bit and the flag is 0.
- R3: One oversampling tick occurs every `divisor` clocks, and a `divisor` of 0 acts as 1. A bit lasts 16 ticks and is sampled at its centre.
- R4: A low level that is high again by the centre of the start bit is discarded, and no entry is written.
- R5: A stop bit that samples low sets the entry's framing-error flag. After that, the receiver waits for the line to go high before it looks for a new start bit.
- R6: When the data, parity and stop bits all sample low, the block writes exactly one break entry: data 0, break flag 1, framing flag 1, parity flag 0. It writes no further entry until the line has returned high.
- R7: The queue holds 64 entries in arrival order. The oldest entry and its flags appear on the read outputs whenever `empty` is 0. A high `rdEn` pops one entry per clock. `level` gives the entry count.
- R8: A character that arrives while the queue is full and no pop happens is discarded, and the stored entries stay unchanged. `overflow` then goes high and stays high until the next pop.
- R9: `lineIdle` rises when the queue is not empty and four character times (in ticks, for the current format, counted from the last start edge) pass with no new start edge. It falls on a start edge or when the queue empties.
- R10: `trigSel` selects a threshold of 8 (0), 16 (1), 56 (2) or 60 (3) entries. `trigReq` is 1 exactly while `level` is at or above the selected threshold.
- R11: While reset is held, `empty`=1, `level`=0, and `overflow`, `trigReq` and `lineIdle` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| divisor | input | 16 | Clocks per oversampling tick (0 acts as 1) |
| wordLen | input | 2 | Data bit count select |
| parityEn | input | 1 | Parity bit present |
| parityOdd | input | 1 | 1 = odd parity, 0 = even parity |
| trigSel | input | 2 | Request threshold select |
| rxLine | input | 1 | Serial input, idle high |
| rdEn | input | 1 | Pop the oldest entry |
| rdData | output | 8 | Data byte of the oldest entry |
| rdParErr | output | 1 | Parity-error flag of the oldest entry |
| rdFrmErr | output | 1 | Framing-error flag of the oldest entry |
| rdBreak | output | 1 | Break flag of the oldest entry |
| level | output | 7 | Number of stored entries |
| empty | output | 1 | Queue holds no entries |
| trigReq | output | 1 | Level is at or above the selected threshold |
| overflow | output | 1 | Sticky flag: a character was lost to a full queue |
| lineIdle | output | 1 | Stored data has waited four character times |

## Verification
A wrong sampling phase or bit count in the receive state machine shows up in the next written entry. It appears as a shifted data byte or a false framing or parity flag one character time after the stimulus. A broken queue pointer or level counter shows up at the first pop that follows, when entries come out of order or `level` drifts from the number of frames sent. A wrong overflow rule shows up once the full queue is drained: 64 pops must return the first 64 characters. A wrong idle or threshold compare shows up at the frame or timeout where the flag should change. The bench checks the trigger output after every frame of a complete fill.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  typedef struct packed {
    logic [7:0] data;
    logic       parErr;
    logic       frmErr;
    logic       brk;
  } rxEntry_t;

  // strobe bundle handed from the control FSM to the queue datapath
  typedef struct packed {
    logic     push;
    rxEntry_t entry;
  } rxStrobe_t;

  typedef enum logic [2:0] {
    S_HUNT, S_START, S_DATA, S_PAR, S_STOP, S_WAITHI
  } rxState_t;
endpackage

// File: rtl/rxf_ctrl.sv
module rxf_ctrl
  import rxf_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divisor,
  input  logic [1:0]       wordLen,
  input  logic             parityEn,
  input  logic             parityOdd,
  input  logic             rxLine,
  input  logic             fifoEmpty,
  output rxStrobe_t        strobe,
  output logic             lineIdle
);
  localparam int TICK_LOG = 4;                 // 16 ticks per bit
  localparam int FRAME_W  = 4;                 // up to 11 bits per frame
  localparam int IDLE_W   = FRAME_W + TICK_LOG + 2;
  localparam logic [TICK_LOG-1:0] MID  = TICK_LOG'((1 << TICK_LOG) / 2 - 1);
  localparam logic [TICK_LOG-1:0] LAST = '1;

  logic             rxMeta, rxSync;
  logic [DIV_W-1:0] divCnt, divLast;
  logic             tick;
  rxState_t         state;
  logic [TICK_LOG-1:0] subCnt;
  logic [2:0]       bitCnt, lastBit;
  logic [7:0]       shiftReg, alignedData;
  logic [1:0]       shamt;
  logic             parBit, brkCond, parMismatch, startEdge;
  logic [FRAME_W-1:0] frameBits;
  logic [IDLE_W-1:0]  idleCnt, idleThresh;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxMeta <= 1'b1;
      rxSync <= 1'b1;
    end else begin
      rxMeta <= rxLine;
      rxSync <= rxMeta;
    end
  end

  assign divLast = (divisor == '0) ? DIV_W'(1) : divisor;
  assign tick    = (divCnt >= divLast - 1'b1);

  always_ff @(posedge clk) begin
    if (!rstN || tick) divCnt <= '0;
    else               divCnt <= divCnt + 1'b1;
  end

  assign lastBit     = 3'd4 + {1'b0, wordLen};
  assign shamt       = 2'd3 - wordLen;
  assign alignedData = shiftReg >> shamt;
  assign parMismatch = parityEn & (^alignedData ^ parBit ^ parityOdd);
  assign brkCond     = !rxSync && (alignedData == 8'd0) && (!parityEn || !parBit);
  assign startEdge   = (state == S_HUNT) && tick && !rxSync;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_HUNT;
      subCnt   <= '0;
      bitCnt   <= '0;
      shiftReg <= '0;
      parBit   <= 1'b0;
      strobe   <= '0;
    end else begin
      strobe.push <= 1'b0;
      unique case (state)
        S_HUNT: if (startEdge) begin
          state  <= S_START;
          subCnt <= '0;
        end
        S_START: if (tick) begin
          if (subCnt == MID) begin
            subCnt <= '0;
            bitCnt <= '0;
            state  <= rxSync ? S_HUNT : S_DATA;
          end else subCnt <= subCnt + 1'b1;
        end
        S_DATA: if (tick) begin
          subCnt <= subCnt + 1'b1;
          if (subCnt == LAST) begin
            shiftReg <= {rxSync, shiftReg[7:1]};
            if (bitCnt == lastBit) state <= parityEn ? S_PAR : S_STOP;
            else                   bitCnt <= bitCnt + 1'b1;
          end
        end
        S_PAR: if (tick) begin
          subCnt <= subCnt + 1'b1;
          if (subCnt == LAST) begin
            parBit <= rxSync;
            state  <= S_STOP;
          end
        end
        S_STOP: if (tick) begin
          subCnt <= subCnt + 1'b1;
          if (subCnt == LAST) begin
            strobe.push         <= 1'b1;
            strobe.entry.data   <= alignedData;
            strobe.entry.brk    <= brkCond;
            strobe.entry.frmErr <= !rxSync;
            strobe.entry.parErr <= brkCond ? 1'b0 : parMismatch;
            state               <= rxSync ? S_HUNT : S_WAITHI;
          end
        end
        S_WAITHI: if (rxSync) state <= S_HUNT;
        default: state <= S_HUNT;
      endcase
    end
  end

  // idle timeout: four frames of 16 ticks each = frameBits * 64 ticks
  assign frameBits  = FRAME_W'(7) + {2'b00, wordLen} + {3'b000, parityEn};
  assign idleThresh = {frameBits, 6'b0};

  always_ff @(posedge clk) begin
    if (!rstN || startEdge)              idleCnt <= '0;
    else if (tick && idleCnt < idleThresh) idleCnt <= idleCnt + 1'b1;
  end

  assign lineIdle = (idleCnt >= idleThresh) && !fifoEmpty;

  assert_start_low_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_DATA && $past(state) == S_START) |-> !$past(rxSync));
  assert_break_entry_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.push && strobe.entry.brk) |-> (strobe.entry.data == 8'd0 && strobe.entry.frmErr
                                           && !strobe.entry.parErr));
  assert_single_push_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.push |=> !strobe.push);
  assert_wait_high_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.push && strobe.entry.frmErr) |-> state == S_WAITHI);
endmodule

// File: rtl/rxf_fifo.sv
module rxf_fifo
  import rxf_pkg::*;
#(
  parameter int DEPTH = 64   // power of two
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  rxStrobe_t              strobe,
  input  logic                   rdEn,
  input  logic [1:0]             trigSel,
  output rxEntry_t               head,
  output logic [$clog2(DEPTH):0] level,
  output logic                   empty,
  output logic                   trigReq,
  output logic                   overflow
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = AW + 1;
  localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);

  rxEntry_t        mem [DEPTH];
  logic [AW-1:0]   wrPtr, rdPtr;
  logic            full, pop, accept;
  logic [LW-1:0]   thresh;

  assign empty  = (level == '0);
  assign full   = (level == FULL_LVL);
  assign pop    = rdEn && !empty;
  assign accept = strobe.push && (!full || pop);
  assign head   = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (accept) mem[wrPtr] <= strobe.entry;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      level    <= '0;
      overflow <= 1'b0;
    end else begin
      if (accept) wrPtr <= wrPtr + 1'b1;
      if (pop)    rdPtr <= rdPtr + 1'b1;
      unique case ({accept, pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
      if (strobe.push && !accept) overflow <= 1'b1;
      else if (pop)               overflow <= 1'b0;
    end
  end

  always_comb begin
    unique case (trigSel)
      2'd0:    thresh = LW'(DEPTH / 8);
      2'd1:    thresh = LW'(DEPTH / 4);
      2'd2:    thresh = LW'(DEPTH - 8);
      default: thresh = LW'(DEPTH - 4);
    endcase
  end

  assign trigReq = (level >= thresh);

  assert_level_bound_R7: assert property (@(posedge clk) disable iff (!rstN)
    level <= FULL_LVL);
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.push && full && !rdEn) |=> level == $past(level));
  assert_ovf_rise_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overflow) |-> $past(level) == FULL_LVL);
  assert_trig_nonempty_R10: assert property (@(posedge clk) disable iff (!rstN)
    trigReq |-> !empty);
endmodule

// File: rtl/rx_line_fifo.sv
module rx_line_fifo
  import rxf_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int DEPTH = 64
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [DIV_W-1:0]       divisor,
  input  logic [1:0]             wordLen,
  input  logic                   parityEn,
  input  logic                   parityOdd,
  input  logic [1:0]             trigSel,
  input  logic                   rxLine,
  input  logic                   rdEn,
  output logic [7:0]             rdData,
  output logic                   rdParErr,
  output logic                   rdFrmErr,
  output logic                   rdBreak,
  output logic [$clog2(DEPTH):0] level,
  output logic                   empty,
  output logic                   trigReq,
  output logic                   overflow,
  output logic                   lineIdle
);
  rxStrobe_t strobe;
  rxEntry_t  head;

  rxf_ctrl #(.DIV_W(DIV_W)) ctrlInst (
    .clk(clk), .rstN(rstN), .divisor(divisor), .wordLen(wordLen),
    .parityEn(parityEn), .parityOdd(parityOdd), .rxLine(rxLine),
    .fifoEmpty(empty), .strobe(strobe), .lineIdle(lineIdle)
  );

  rxf_fifo #(.DEPTH(DEPTH)) fifoInst (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rdEn(rdEn), .trigSel(trigSel),
    .head(head), .level(level), .empty(empty), .trigReq(trigReq),
    .overflow(overflow)
  );

  assign rdData   = head.data;
  assign rdParErr = head.parErr;
  assign rdFrmErr = head.frmErr;
  assign rdBreak  = head.brk;
endmodule

// File: tb/rx_line_fifo_test.sv
module rx_line_fifo_test;
  logic        clk = 1'b0;
  logic        rstN;
  logic [15:0] divisor;
  logic [1:0]  wordLen, trigSel;
  logic        parityEn, parityOdd, rxLine, rdEn;
  logic [7:0]  rdData;
  logic        rdParErr, rdFrmErr, rdBreak, empty, trigReq, overflow, lineIdle;
  logic [6:0]  level;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;   // 125 MHz

  rx_line_fifo uut (
    .clk(clk), .rstN(rstN), .divisor(divisor), .wordLen(wordLen),
    .parityEn(parityEn), .parityOdd(parityOdd), .trigSel(trigSel),
    .rxLine(rxLine), .rdEn(rdEn), .rdData(rdData), .rdParErr(rdParErr),
    .rdFrmErr(rdFrmErr), .rdBreak(rdBreak), .level(level), .empty(empty),
    .trigReq(trigReq), .overflow(overflow), .lineIdle(lineIdle)
  );

  typedef struct packed {
    logic [1:0] wl;
    logic       pen;
    logic       podd;
    logic [7:0] data;
    logic       flip;
    logic       stopLow;
    logic [7:0] expData;
    logic       expPar;
    logic       expFrm;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{2'd3, 1'b0, 1'b0, 8'hA5, 1'b0, 1'b0, 8'hA5, 1'b0, 1'b0},  // R1 8 bits
    '{2'd0, 1'b0, 1'b0, 8'hFF, 1'b0, 1'b0, 8'h1F, 1'b0, 1'b0},  // R1 5 bits
    '{2'd1, 1'b0, 1'b0, 8'h2A, 1'b0, 1'b0, 8'h2A, 1'b0, 1'b0},  // R1 6 bits
    '{2'd2, 1'b0, 1'b0, 8'h55, 1'b0, 1'b0, 8'h55, 1'b0, 1'b0},  // R1 7 bits
    '{2'd3, 1'b1, 1'b0, 8'h03, 1'b0, 1'b0, 8'h03, 1'b0, 1'b0},  // R2 even ok
    '{2'd3, 1'b1, 1'b0, 8'h07, 1'b1, 1'b0, 8'h07, 1'b1, 1'b0},  // R2 even bad
    '{2'd2, 1'b1, 1'b1, 8'h41, 1'b0, 1'b0, 8'h41, 1'b0, 1'b0},  // R2 odd ok
    '{2'd3, 1'b1, 1'b1, 8'h80, 1'b1, 1'b0, 8'h80, 1'b1, 1'b0},  // R2 odd bad
    '{2'd3, 1'b0, 1'b0, 8'h3C, 1'b0, 1'b1, 8'h3C, 1'b0, 1'b1},  // R5 stop low
    '{2'd3, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0}   // R6 not a break
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int bitClks();
    return 16 * ((divisor == 16'd0) ? 1 : int'(divisor));
  endfunction

  task automatic holdLine(input logic v, input int clks);
    rxLine = v;
    repeat (clks) @(negedge clk);
  endtask

  task automatic sendFrame(input logic [7:0] d, input logic flip, input logic stopLow);
    int n = 5 + int'(wordLen);
    logic ones = 1'b0;
    holdLine(1'b0, bitClks());
    for (int i = 0; i < n; i++) begin
      holdLine(d[i], bitClks());
      ones ^= d[i];
    end
    if (parityEn) holdLine(ones ^ parityOdd ^ flip, bitClks());
    holdLine(!stopLow, bitClks());
    holdLine(1'b1, bitClks());
  endtask

  task automatic popOne();
    rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  function automatic int thrFor(input logic [1:0] s);
    case (s)
      2'd0: return 8;
      2'd1: return 16;
      2'd2: return 56;
      default: return 60;
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; divisor = 16'd2; wordLen = 2'd3; parityEn = 1'b0;
    parityOdd = 1'b0; trigSel = 2'd0; rxLine = 1'b1; rdEn = 1'b0;
    repeat (5) @(negedge clk);
    chk("R11 empty", empty, 1);
    chk("R11 level", level, 0);
    chk("R11 overflow", overflow, 0);
    chk("R11 trigReq", trigReq, 0);
    chk("R11 lineIdle", lineIdle, 0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    // table of formats, parity and framing cases (R1 R2 R5)
    for (int v = 0; v < NV; v++) begin
      wordLen = VECS[v].wl; parityEn = VECS[v].pen; parityOdd = VECS[v].podd;
      sendFrame(VECS[v].data, VECS[v].flip, VECS[v].stopLow);
      chk("R7 level after frame", level, 1);
      chk("R1 data", rdData, VECS[v].expData);
      chk("R2 parity flag", rdParErr, VECS[v].expPar);
      chk("R5 framing flag", rdFrmErr, VECS[v].expFrm);
      chk("R6 no break", rdBreak, 0);
      popOne();
      chk("R7 empty after pop", empty, 1);
    end
    wordLen = 2'd3; parityEn = 1'b0; parityOdd = 1'b0;

    // R3 other divisors
    divisor = 16'd5;
    sendFrame(8'h5A, 1'b0, 1'b0);
    chk("R3 divisor 5 data", rdData, 8'h5A);
    popOne();
    divisor = 16'd0;
    sendFrame(8'hC3, 1'b0, 1'b0);
    chk("R3 divisor 0 data", rdData, 8'hC3);
    chk("R3 divisor 0 level", level, 1);
    popOne();
    divisor = 16'd2;

    // R4 glitch: 4 ticks low then high
    holdLine(1'b0, 8);
    holdLine(1'b1, 3 * bitClks());
    chk("R4 glitch ignored", level, 0);

    // R6 break: long low, then high
    holdLine(1'b0, 30 * bitClks());
    chk("R6 one entry during break", level, 1);
    holdLine(1'b1, 2 * bitClks());
    chk("R6 single entry", level, 1);
    chk("R6 break data", rdData, 0);
    chk("R6 break flag", rdBreak, 1);
    chk("R6 break framing", rdFrmErr, 1);
    chk("R6 break parity", rdParErr, 0);
    popOne();

    // R9 idle timeout (8N1: 4*10*16 ticks*2 clocks = 1280 clocks after start)
    sendFrame(8'h11, 1'b0, 1'b0);
    chk("R9 not idle yet", lineIdle, 0);
    repeat (1000) @(negedge clk);
    chk("R9 idle asserted", lineIdle, 1);
    popOne();
    chk("R9 idle clears when empty", lineIdle, 0);

    // R10 thresholds while filling, then R8 overflow
    for (int i = 0; i < 64; i++) begin
      logic [1:0] sel = (i < 8) ? 2'd0 : (i < 16) ? 2'd1 : (i < 56) ? 2'd2 : 2'd3;
      trigSel = sel;
      sendFrame(8'(i), 1'b0, 1'b0);
      chk("R10 trigReq", trigReq, (i + 1 >= thrFor(sel)) ? 1 : 0);
    end
    trigSel = 2'd0;
    chk("R7 full level", level, 64);
    chk("R8 no overflow yet", overflow, 0);
    sendFrame(8'hEE, 1'b0, 1'b0);
    chk("R8 level kept", level, 64);
    chk("R8 overflow set", overflow, 1);
    for (int i = 0; i < 64; i++) begin
      chk("R8 contents intact", rdData, 8'(i));
      popOne();
      if (i == 0) chk("R8 overflow cleared by pop", overflow, 0);
    end
    chk("R7 drained", empty, 1);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule